// File: doc/BRIEF.md
# Self-Test Sequencer for an Electrically Erasable Page Array

This controller tests an embedded electrically erasable memory built from pages. A page is one row of `PAGE_BYTES` words and is staged in a small page latch RAM that writes at SRAM speed. While `test_mode` is high, a port mux gives the controller every array input. The array itself and its charge pump are outside the block; read data comes back on `arr_rdata`.

The run has two parts. The latch RAM is tested first by direct write and read-back. The core is then tested with whole-array operations. The block erase, block write and parity page write modes cover the whole core with only eight timed programming steps, and two of those steps build a full checkerboard. Each programming step holds the high-voltage enable for a fixed count of clock cycles. `good` falls on the first miscompare and stays low. `done` rises once the last comparison has settled.

Top module: `ee_bist_seq`

## Requirements
- R1: While `test_mode` is low, every array output equals its `sys_*` counterpart and the sequencer stays at its first step. The run starts on the first cycle with `test_mode` high, and that cycle presents latch write (mode 2) at address 0.
- R2: Before any programming step, the latch RAM is written at all `PAGE_BYTES` addresses with a checkerboard, read back, then written and read back with its inverse. The checkerboard holds 0x55 at even latch addresses and 0xAA at odd ones. The inverse swaps these two values. Latch writes use mode 2 with `arr_latch_we` high. Latch reads use mode 3.
- R3: The eight programming steps use these modes in this order: erase, block write, block write, parity write, parity write, erase, parity write, parity write. The mode codes are erase 5, block write 6 and parity write 7. No other step raises `arr_hv_en`.
- R4: The latch contents at the start of each write step are all-0x00 and all-0xFF for the two block writes. For the four parity writes they are 0xAA, 0x55, 0x55 and 0xAA, in that order.
- R5: During a parity write, `arr_addr` is 1 to program odd pages and 0 to program even pages. The four parity writes target odd, even, odd and even pages in that order.
- R6: Each programming step keeps `arr_hv_en` high for exactly `PROG_WAIT` consecutive cycles.
- R7: Each core read (mode 1) walks every word address in ascending order. There are five sweeps, in this order: after the first erase, after the 0x00 write, after the 0xFF write, after the checkerboard and after its inverse. In the checkerboard, odd pages hold 0xAA and even pages hold 0x55; the inverse swaps them. At the end of the run, the core holds odd pages 0x55 and even pages 0xAA.
- R8: Read data is compared one cycle after its address is presented. A miscompare lowers `good` two clock edges after the cycle that presented the failing address.
- R9: Once low, `good` stays low until reset, and the run still reaches `done`.
- R10: `done` rises two edges after the last core read address and then holds. Mode stays 0, and `arr_hv_en` and `arr_latch_we` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running test clock; also times programming |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | Gives the sequencer ownership of the array inputs |
| sys_mode | input | 4 | Functional-path mode |
| sys_addr | input | ADDR_W | Functional-path address |
| sys_wdata | input | WORD_W | Functional-path write data |
| sys_latch_we | input | 1 | Functional-path latch write strobe |
| sys_hv_en | input | 1 | Functional-path program-voltage enable |
| arr_rdata | input | WORD_W | Read data from the array, one cycle after the address |
| arr_mode | output | 4 | Mode to the array |
| arr_addr | output | ADDR_W | Word, latch or page-parity address to the array |
| arr_wdata | output | WORD_W | Latch write data to the array |
| arr_latch_we | output | 1 | Latch write strobe |
| arr_hv_en | output | 1 | Program-voltage generator enable |
| done | output | 1 | Run complete |
| good | output | 1 | Sticky pass flag |

## Verification
The bench samples on the falling edge and uses a behavioural array model. That model stores latch writes and programming effects at the rising edge, and it registers read data so the data is present one cycle after its address. A miscompare injected at a chosen word must appear as `good` low exactly two samples after that address. `done` must rise exactly two samples after the last core read address. Programming-step lengths, mode order, parity select and the latch contents when each step starts are all measured at the ports against a fixed list computed in the bench. The final contents of the model core are compared word by word with the inverse checkerboard.

// File: rtl/ee_bist_pkg.sv
package ee_bist_pkg;

   typedef enum logic [3:0] {
      MD_IDLE      = 4'd0,
      MD_CORE_RD   = 4'd1,
      MD_LATCH_WR  = 4'd2,
      MD_LATCH_RD  = 4'd3,
      MD_PAGE_PROG = 4'd4,
      MD_BLK_ERASE = 4'd5,
      MD_BLK_WRITE = 4'd6,
      MD_PAR_WRITE = 4'd7
   } arr_mode_e;

   typedef enum logic [2:0] {
      OP_LOAD, OP_LCHK, OP_ERASE, OP_BWR, OP_PWR, OP_CCHK, OP_END
   } op_e;

   typedef enum logic [2:0] {
      PT_ZERO, PT_ONE, PT_A, PT_5, PT_LCB, PT_LCBI, PT_CCB, PT_CCBI
   } pat_e;

   typedef struct packed {
      op_e  op;
      pat_e pat;
      logic odd;
   } step_t;

   localparam int STEP_W = 5;

   function automatic step_t step_at(input logic [STEP_W-1:0] i);
      step_t s;
      s = '{op: OP_END, pat: PT_ZERO, odd: 1'b0};
      case (i)
         5'd0:  s = '{OP_LOAD,  PT_LCB,  1'b0};
         5'd1:  s = '{OP_LCHK,  PT_LCB,  1'b0};
         5'd2:  s = '{OP_LOAD,  PT_LCBI, 1'b0};
         5'd3:  s = '{OP_LCHK,  PT_LCBI, 1'b0};
         5'd4:  s = '{OP_ERASE, PT_ONE,  1'b0};
         5'd5:  s = '{OP_CCHK,  PT_ONE,  1'b0};
         5'd6:  s = '{OP_LOAD,  PT_ZERO, 1'b0};
         5'd7:  s = '{OP_BWR,   PT_ZERO, 1'b0};
         5'd8:  s = '{OP_CCHK,  PT_ZERO, 1'b0};
         5'd9:  s = '{OP_LOAD,  PT_ONE,  1'b0};
         5'd10: s = '{OP_BWR,   PT_ONE,  1'b0};
         5'd11: s = '{OP_CCHK,  PT_ONE,  1'b0};
         5'd12: s = '{OP_LOAD,  PT_A,    1'b0};
         5'd13: s = '{OP_PWR,   PT_A,    1'b1};
         5'd14: s = '{OP_LOAD,  PT_5,    1'b0};
         5'd15: s = '{OP_PWR,   PT_5,    1'b0};
         5'd16: s = '{OP_CCHK,  PT_CCB,  1'b0};
         5'd17: s = '{OP_ERASE, PT_ONE,  1'b0};
         5'd18: s = '{OP_LOAD,  PT_5,    1'b0};
         5'd19: s = '{OP_PWR,   PT_5,    1'b1};
         5'd20: s = '{OP_LOAD,  PT_A,    1'b0};
         5'd21: s = '{OP_PWR,   PT_A,    1'b0};
         5'd22: s = '{OP_CCHK,  PT_CCBI, 1'b0};
         default: s = '{OP_END, PT_ZERO, 1'b0};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ee_bist_ctrl.sv
module ee_bist_ctrl
   import ee_bist_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int NUM_PAGES  = 256,
   parameter int PROG_WAIT  = 65000,
   parameter int ADDR_W     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic [3:0]        b_mode,
   output logic [ADDR_W-1:0] b_addr,
   output logic [WORD_W-1:0] b_wdata,
   output logic              b_latch_we,
   output logic              b_hv_en,
   output logic              rd_issue,
   output logic [WORD_W-1:0] rd_exp,
   output logic              seq_end
);
   localparam int WORDS = PAGE_BYTES * NUM_PAGES;
   localparam int LB_W  = $clog2(PAGE_BYTES);
   localparam int PW_W  = $clog2(PROG_WAIT + 1);
   localparam int CNT_W = (ADDR_W > PW_W) ? ADDR_W : PW_W;

   logic [STEP_W-1:0] step_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_val;
   step_t             cur;
   logic [WORD_W-1:0] pat_a, pat_5, pat_v;
   logic              page_odd, addr_odd;

   genvar g;
   generate
      for (g = 0; g < WORD_W; g++) begin : g_alt
         assign pat_a[g] = g[0];
      end
   endgenerate
   assign pat_5 = ~pat_a;

   assign cur      = step_at(step_q);
   assign page_odd = cnt_q[LB_W];
   assign addr_odd = cnt_q[0];

   always_comb begin
      unique case (cur.op)
         OP_LOAD, OP_LCHK:        last_val = CNT_W'(PAGE_BYTES - 1);
         OP_CCHK:                 last_val = CNT_W'(WORDS - 1);
         OP_ERASE, OP_BWR, OP_PWR: last_val = CNT_W'(PROG_WAIT - 1);
         default:                 last_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
         cnt_q  <= '0;
      end else if (run && cur.op != OP_END) begin
         if (cnt_q == last_val) begin
            cnt_q  <= '0;
            step_q <= step_q + 1'b1;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      unique case (cur.pat)
         PT_ZERO: pat_v = '0;
         PT_ONE:  pat_v = '1;
         PT_A:    pat_v = pat_a;
         PT_5:    pat_v = pat_5;
         PT_LCB:  pat_v = addr_odd ? pat_a : pat_5;
         PT_LCBI: pat_v = addr_odd ? pat_5 : pat_a;
         PT_CCB:  pat_v = page_odd ? pat_a : pat_5;
         default: pat_v = page_odd ? pat_5 : pat_a;
      endcase
   end

   always_comb begin
      b_mode     = MD_IDLE;
      b_addr     = '0;
      b_wdata    = '0;
      b_latch_we = 1'b0;
      b_hv_en    = 1'b0;
      rd_issue   = 1'b0;
      rd_exp     = pat_v;
      seq_end    = 1'b0;
      unique case (cur.op)
         OP_LOAD: begin
            b_mode     = MD_LATCH_WR;
            b_addr     = cnt_q[ADDR_W-1:0];
            b_wdata    = pat_v;
            b_latch_we = 1'b1;
         end
         OP_LCHK: begin
            b_mode   = MD_LATCH_RD;
            b_addr   = cnt_q[ADDR_W-1:0];
            rd_issue = run;
         end
         OP_CCHK: begin
            b_mode   = MD_CORE_RD;
            b_addr   = cnt_q[ADDR_W-1:0];
            rd_issue = run;
         end
         OP_ERASE: begin
            b_mode  = MD_BLK_ERASE;
            b_hv_en = 1'b1;
         end
         OP_BWR: begin
            b_mode  = MD_BLK_WRITE;
            b_hv_en = 1'b1;
         end
         OP_PWR: begin
            b_mode  = MD_PAR_WRITE;
            b_addr  = ADDR_W'(cur.odd);
            b_hv_en = 1'b1;
         end
         default: seq_end = 1'b1;
      endcase
   end
endmodule

// File: rtl/ee_bist_cmp.sv
module ee_bist_cmp #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [WORD_W-1:0] exp_in,
   input  logic [WORD_W-1:0] rdata,
   output logic              busy,
   output logic              good
);
   logic              valid_q;
   logic [WORD_W-1:0] exp_q;
   logic              good_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         exp_q   <= '0;
         good_q  <= 1'b1;
      end else begin
         valid_q <= issue;
         exp_q   <= exp_in;
         if (valid_q && rdata != exp_q) good_q <= 1'b0;
      end
   end

   assign busy = valid_q;
   assign good = good_q;
endmodule

// File: rtl/ee_bist_port_mux.sv
module ee_bist_port_mux #(
   parameter int W = 8
) (
   input  logic         sel_test,
   input  logic [W-1:0] func_in,
   input  logic [W-1:0] test_in,
   output logic [W-1:0] y
);
   assign y = sel_test ? test_in : func_in;
endmodule

// File: rtl/ee_bist_seq.sv
module ee_bist_seq
   import ee_bist_pkg::*;
#(
   parameter int WORD_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int NUM_PAGES  = 256,
   parameter int PROG_WAIT  = 65000,
   localparam int ADDR_W    = $clog2(PAGE_BYTES * NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_mode,
   input  logic [3:0]        sys_mode,
   input  logic [ADDR_W-1:0] sys_addr,
   input  logic [WORD_W-1:0] sys_wdata,
   input  logic              sys_latch_we,
   input  logic              sys_hv_en,
   input  logic [WORD_W-1:0] arr_rdata,
   output logic [3:0]        arr_mode,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [WORD_W-1:0] arr_wdata,
   output logic              arr_latch_we,
   output logic              arr_hv_en,
   output logic              done,
   output logic              good
);
   localparam int BUS_W = 4 + ADDR_W + WORD_W + 2;

   generate
      if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2)
         $error("PAGE_BYTES must be a power of two of at least 2");
      if ((NUM_PAGES & (NUM_PAGES - 1)) != 0 || NUM_PAGES < 2)
         $error("NUM_PAGES must be a power of two of at least 2");
      if (WORD_W < 2 || (WORD_W % 2) != 0)
         $error("WORD_W must be even");
      if (PROG_WAIT < 1)
         $error("PROG_WAIT must be positive");
   endgenerate

   logic [3:0]        b_mode;
   logic [ADDR_W-1:0] b_addr;
   logic [WORD_W-1:0] b_wdata;
   logic              b_latch_we, b_hv_en, rd_issue, seq_end, cmp_busy;
   logic [WORD_W-1:0] rd_exp;
   logic [BUS_W-1:0]  bus_y;

   ee_bist_ctrl #(
      .WORD_W(WORD_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
      .PROG_WAIT(PROG_WAIT), .ADDR_W(ADDR_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .run(test_mode),
      .b_mode(b_mode), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_latch_we(b_latch_we), .b_hv_en(b_hv_en),
      .rd_issue(rd_issue), .rd_exp(rd_exp), .seq_end(seq_end)
   );

   ee_bist_cmp #(.WORD_W(WORD_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .issue(rd_issue), .exp_in(rd_exp),
      .rdata(arr_rdata), .busy(cmp_busy), .good(good)
   );

   ee_bist_port_mux #(.W(BUS_W)) u_mux (
      .sel_test(test_mode),
      .func_in({sys_mode, sys_addr, sys_wdata, sys_latch_we, sys_hv_en}),
      .test_in({b_mode, b_addr, b_wdata, b_latch_we, b_hv_en}),
      .y(bus_y)
   );

   assign {arr_mode, arr_addr, arr_wdata, arr_latch_we, arr_hv_en} = bus_y;
   assign done = seq_end && !cmp_busy;
endmodule

// File: rtl/ee_bist_seq_chk.sv
module ee_bist_seq_chk #(
   parameter int WORD_W    = 8,
   parameter int ADDR_W    = 13,
   parameter int PROG_WAIT = 65000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_mode,
   input logic [3:0]        arr_mode,
   input logic [ADDR_W-1:0] arr_addr,
   input logic              arr_latch_we,
   input logic              arr_hv_en,
   input logic              done,
   input logic              good
);
   int unsigned run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                       run_cnt <= 0;
      else if (test_mode && arr_hv_en)  run_cnt <= run_cnt + 1;
      else                              run_cnt <= 0;
   end

   assert_prog_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= PROG_WAIT);

   assert_prog_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && $past(test_mode) && $fell(arr_hv_en)) |-> run_cnt == PROG_WAIT);

   assert_hv_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && arr_hv_en) |-> (arr_mode == 4'd5 || arr_mode == 4'd6 || arr_mode == 4'd7));

   assert_parity_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && arr_mode == 4'd7) |-> (arr_addr >> 1) == '0);

   assert_latch_we_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && arr_latch_we) |-> arr_mode == 4'd2);

   assert_good_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !good |=> !good);

   assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(good)));

   assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && test_mode) |-> (!arr_hv_en && !arr_latch_we && arr_mode == 4'd0));
endmodule

bind ee_bist_seq ee_bist_seq_chk #(
   .WORD_W(WORD_W), .ADDR_W(ADDR_W), .PROG_WAIT(PROG_WAIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .arr_mode(arr_mode),
   .arr_addr(arr_addr), .arr_latch_we(arr_latch_we), .arr_hv_en(arr_hv_en),
   .done(done), .good(good)
);

// File: tb/sim_ee_bist_seq.sv
module sim_ee_bist_seq;
   localparam int PB = 4;
   localparam int NP = 4;
   localparam int PW = 6;
   localparam int NW = PB * NP;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          test_mode = 1'b0;
   logic [3:0]    sys_mode = '0;
   logic [AW-1:0] sys_addr = '0;
   logic [7:0]    sys_wdata = '0;
   logic          sys_latch_we = 1'b0;
   logic          sys_hv_en = 1'b0;
   logic [7:0]    arr_rdata;
   logic [3:0]    arr_mode;
   logic [AW-1:0] arr_addr;
   logic [7:0]    arr_wdata;
   logic          arr_latch_we, arr_hv_en, done, good;

   always #2 clk = ~clk;

   ee_bist_seq #(.WORD_W(8), .PAGE_BYTES(PB), .NUM_PAGES(NP), .PROG_WAIT(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .sys_mode(sys_mode),
      .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_latch_we(sys_latch_we),
      .sys_hv_en(sys_hv_en), .arr_rdata(arr_rdata), .arr_mode(arr_mode),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_latch_we(arr_latch_we),
      .arr_hv_en(arr_hv_en), .done(done), .good(good)
   );

   // array model
   logic [7:0] lat  [PB];
   logic [7:0] core [NW];
   int fault_core = -1;
   int fault_lat  = -1;

   always @(posedge clk) begin
      if (arr_latch_we) lat[arr_addr[1:0]] <= arr_wdata;
      if (arr_hv_en) begin
         for (int w = 0; w < NW; w++) begin
            if (arr_mode == 4'd5) core[w] <= 8'hFF;
            else if (arr_mode == 4'd6) core[w] <= lat[w % PB];
            else if (arr_mode == 4'd7 && ((w / PB) % 2) == int'(arr_addr[0]))
               core[w] <= lat[w % PB];
         end
      end
      if (arr_mode == 4'd1)
         arr_rdata <= (int'(arr_addr) == fault_core) ? (core[arr_addr] & 8'hFE) : core[arr_addr];
      else if (arr_mode == 4'd3)
         arr_rdata <= (int'(arr_addr) == fault_lat) ? (lat[arr_addr[1:0]] & 8'hFE) : lat[arr_addr[1:0]];
      else
         arr_rdata <= 8'h00;
   end

   // port monitor
   int cyc = 0;
   int lw_n, lw_bad, lr_n, prog_n, len_bad, run_len, cr_n, cr_bad;
   int first5, last_rd, gfall, done_cyc, first_hv, last_lat_op;
   logic prev_hv;
   int   rec_mode [8];
   int   rec_odd  [8];
   logic [7:0] rec_lat [8][PB];
   logic [7:0] e;

   always @(negedge clk) begin
      if (rst_n && test_mode) begin
         if (arr_latch_we && prog_n == 0) begin
            if (((lw_n / PB) % 2) == 0) e = arr_addr[0] ? 8'hAA : 8'h55;
            else                        e = arr_addr[0] ? 8'h55 : 8'hAA;
            if (arr_wdata != e) lw_bad++;
            lw_n++;
            last_lat_op = cyc;
         end
         if (arr_mode == 4'd3) begin
            lr_n++;
            last_lat_op = cyc;
         end
         if (arr_hv_en && !prev_hv) begin
            if (prog_n < 8) begin
               rec_mode[prog_n] = int'(arr_mode);
               rec_odd[prog_n]  = int'(arr_addr);
               for (int i = 0; i < PB; i++) rec_lat[prog_n][i] = lat[i];
            end
            if (first_hv < 0) first_hv = cyc;
            prog_n++;
         end
         if (arr_hv_en) run_len++;
         else if (prev_hv) begin
            if (run_len != PW) len_bad++;
            run_len = 0;
         end
         if (arr_mode == 4'd1) begin
            if (int'(arr_addr) != cr_n % NW) cr_bad++;
            if (arr_addr == 5 && first5 < 0) first5 = cyc;
            if (cr_n == 5 * NW - 1) last_rd = cyc;
            cr_n++;
         end
         if (!good && gfall < 0) gfall = cyc;
         if (done && done_cyc < 0) done_cyc = cyc;
         prev_hv = arr_hv_en;
      end
      cyc++;
   end

   int n_tests = 0;
   int n_fail  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      lw_n = 0; lw_bad = 0; lr_n = 0; prog_n = 0; len_bad = 0; run_len = 0;
      cr_n = 0; cr_bad = 0; first5 = -1; last_rd = -1; gfall = -1;
      done_cyc = -1; first_hv = -1; last_lat_op = -1; prev_hv = 1'b0;
   endtask

   task automatic run_seq();
      int n;
      test_mode = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      clear_mon();
      test_mode = 1'b1;
      n = 0;
      while (done !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 5000, "watchdog R10", n, 5000);
      @(negedge clk);
   endtask

   int exp_mode [8] = '{5, 6, 6, 7, 7, 5, 7, 7};
   int exp_odd  [8] = '{0, 0, 0, 1, 0, 0, 1, 0};
   int exp_lat  [8] = '{-1, 8'h00, 8'hFF, 8'hAA, 8'h55, -1, 8'h55, 8'hAA};

   initial begin
      int bad;
      clear_mon();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: functional path while test_mode low
      sys_mode = 4'd9; sys_addr = 4'hC; sys_wdata = 8'h3C; sys_latch_we = 1'b1; sys_hv_en = 1'b1;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(arr_mode == 4'd9 && arr_addr == 4'hC && arr_wdata == 8'h3C && arr_latch_we && arr_hv_en,
          "R1 passthrough", int'(arr_wdata), 8'h3C);
      chk(done == 1'b0 && good == 1'b1, "R1 reset state", int'({done, good}), 1);
      sys_latch_we = 1'b0; sys_hv_en = 1'b0; sys_mode = '0;
      test_mode = 1'b1;
      #0.5;
      chk(arr_mode == 4'd2 && arr_addr == 0 && arr_latch_we, "R1 first step", int'(arr_mode), 2);
      test_mode = 1'b0;

      // clean run
      run_seq();
      chk(good == 1'b1, "R9 clean good", int'(good), 1);
      chk(lw_n == 2 * PB && lw_bad == 0, "R2 latch writes", lw_n - lw_bad, 2 * PB);
      chk(lr_n == 2 * PB && last_lat_op < first_hv, "R2 latch reads first", lr_n, 2 * PB);
      chk(prog_n == 8, "R3 program count", prog_n, 8);
      bad = 0;
      for (int i = 0; i < 8; i++) if (rec_mode[i] != exp_mode[i]) bad++;
      chk(bad == 0, "R3 mode order", bad, 0);
      bad = 0;
      for (int i = 0; i < 8; i++)
         if (exp_lat[i] >= 0)
            for (int j = 0; j < PB; j++) if (int'(rec_lat[i][j]) != exp_lat[i]) bad++;
      chk(bad == 0, "R4 latch data at program", bad, 0);
      bad = 0;
      for (int i = 0; i < 8; i++) if (rec_mode[i] == 7 && rec_odd[i] != exp_odd[i]) bad++;
      chk(bad == 0, "R5 parity select", bad, 0);
      chk(len_bad == 0, "R6 program length", len_bad, 0);
      chk(cr_n == 5 * NW && cr_bad == 0, "R7 read sweeps", cr_n - cr_bad, 5 * NW);
      bad = 0;
      for (int w = 0; w < NW; w++)
         if (core[w] != ((((w / PB) % 2) == 1) ? 8'h55 : 8'hAA)) bad++;
      chk(bad == 0, "R7 final inverse checkerboard", bad, 0);
      chk(done_cyc - last_rd == 2, "R10 done timing", done_cyc - last_rd, 2);
      repeat (5) @(negedge clk);
      chk(done && arr_mode == 0 && !arr_hv_en && !arr_latch_we, "R10 done hold", int'(done), 1);

      // core fault
      fault_core = 5;
      run_seq();
      chk(gfall >= 0 && gfall - first5 == 2, "R8 miscompare timing", gfall - first5, 2);
      chk(good == 1'b0 && done == 1'b1, "R9 sticky good", int'(good), 0);

      // latch fault
      fault_core = -1;
      fault_lat  = 0;
      run_seq();
      chk(gfall >= 0 && gfall < first_hv, "R2 latch fault before program", gfall, first_hv);
      chk(good == 1'b0, "R9 latch fault sticky", int'(good), 0);
      fault_lat = -1;

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule